// File: doc/BRIEF.md
# External Memory Cycle Sequencer

This block runs memory transfers on an external asynchronous memory bus while its master already owns that bus. Its bus is an 8-bit data path and a 19-bit address. The address leaves the block in three pieces: a low byte, a high byte and a 3-bit bank field. The block drives the active-low request, read and write strobes. It also controls the direction of the data pins through an output-enable. The pad ring turns `busOut`/`dataOe` into the real bidirectional pins and returns the pin level on `busIn`.

The host pulses `start` together with a command, a start address and a byte count. A transfer of any length keeps the memory request low from the first byte to the last, steps the address by one per byte and gives each byte its own read or write strobe. A write holds its strobe low for two cycles. A read holds its strobe low for three cycles. Write bytes come from a simple stream: `wrTake` marks each cycle in which the block consumes `wrData`. A fill consumes one byte and writes it to the whole range. Read bytes come back on `rdData` with `rdValid`. A single `done` pulse closes every transfer, including one of length zero.

Top module: `memCycleSeq`

## Requirements
- R1: After reset `mreqN`, `rdN` and `wrN` are high, and `dataOe`, `busy`, `done` and `rdValid` are low.
- R2: The address of byte k is (start address + k) modulo 2^19. Bits 7..0 appear on `addrLo`, bits 15..8 on `addrHi` and bits 18..16 on `addrBank`.
- R3: In a write, `wrN` is low for exactly 2 cycles per byte. `dataOe` is high in the cycle before `wrN` falls and in the cycle after it rises.
- R4: In a read, `dataOe` is low while `rdN` is low, and `rdN` is low for exactly 3 cycles per byte. `busIn` is sampled in the last low cycle and appears on `rdData` with `rdValid` high in the next cycle.
- R5: `mreqN` falls once per non-empty transfer, is low whenever a strobe is low, and rises only after the last byte's strobe.
- R6: Fill (`cmd` = 2'b11) writes the byte present at `start` to every address of the range and asserts `wrTake` once.
- R7: Write (`cmd` = 2'b01) consumes one `wrData` byte per address in order. `wrTake` is high in the cycle of each consumption, and the next byte must be on `wrData` by the next such cycle.
- R8: `done` is a one-cycle pulse len*4+1 cycles after the start edge for writes and fills, and len*5+1 cycles after it for reads (`cmd` = 2'b00 or 2'b10).
- R9: A length of zero raises `done` in the cycle after the start edge, with no strobe, no request and no `wrTake`.
- R10: `start` is ignored while `busy` is high.
- R11: `rdN` and `wrN` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| cmd | input | 2 | 00/10 read, 01 write, 11 fill |
| startAddr | input | 19 | First byte address |
| len | input | 8 | Byte count |
| wrData | input | 8 | Write byte stream |
| wrTake | output | 1 | `wrData` is consumed at this edge |
| addrLo | output | 8 | Address bits 7..0 |
| addrHi | output | 8 | Address bits 15..8 |
| addrBank | output | 3 | Address bits 18..16 |
| busOut | output | 8 | Data to the pins |
| dataOe | output | 1 | Drive data pins |
| busIn | input | 8 | Data from the pins |
| mreqN | output | 1 | Memory request, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| rdData | output | 8 | Captured read byte |
| rdValid | output | 1 | `rdData` is new this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |

## Verification
Each byte costs a fixed number of cycles: four for a write and five for a read. That makes `done` due exactly len*4+1 or len*5+1 falling edges after the start edge. The bench counts falling edges from that edge and compares the edge that carries `done` with that figure. Strobe widths, setup and hold of the write data, and the addresses are checked at the falling edge where each strobe changes. A read byte is expected on `rdData` one cycle after its strobe rises, at the edge where `rdValid` shows. All these samples are taken at falling clock edges, away from the rising edge that moves the design.

// File: rtl/memSeqPkg.sv
package memSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } seqStateE;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadAddr;
    logic incAddr;
    logic loadData;
    logic capture;
    logic mreqLow;
    logic rdLow;
    logic wrLow;
    logic drive;
  } seqCtlS;

endpackage

// File: rtl/memSeqCtrl.sv
module memSeqCtrl
  import memSeqPkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int WR_LOW = 2,
  parameter int RD_LOW = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       cmd,
  input  logic [LEN_W-1:0] len,
  output seqCtlS           ctl,
  output logic             busy,
  output logic             done
);

  localparam int MAX_LOW = (WR_LOW > RD_LOW) ? WR_LOW : RD_LOW;
  localparam int CNT_W   = $clog2(MAX_LOW + 1);

  seqStateE         stateQ, stateD;
  logic             isWriteQ, isFillQ;
  logic [LEN_W-1:0] lenLeftQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] strobeLim;
  logic             lastByte, accept, strobeEnd;

  assign strobeLim = isWriteQ ? CNT_W'(WR_LOW - 1) : CNT_W'(RD_LOW - 1);
  assign lastByte  = (lenLeftQ == LEN_W'(1));
  assign accept    = (stateQ == ST_IDLE) && start;
  assign strobeEnd = (cntQ == strobeLim);

  always_comb begin
    ctl    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (accept && (len != '0)) begin
          stateD       = ST_SETUP;
          ctl.loadAddr = 1'b1;
          ctl.loadData = cmd[0];
        end
      end
      ST_SETUP: begin
        ctl.mreqLow = 1'b1;
        ctl.drive   = isWriteQ;
        stateD      = ST_STROBE;
      end
      ST_STROBE: begin
        ctl.mreqLow = 1'b1;
        ctl.drive   = isWriteQ;
        ctl.wrLow   = isWriteQ;
        ctl.rdLow   = !isWriteQ;
        if (strobeEnd) begin
          stateD      = ST_HOLD;
          ctl.capture = !isWriteQ;
        end
      end
      ST_HOLD: begin
        ctl.mreqLow = 1'b1;
        ctl.drive   = isWriteQ;
        if (lastByte) begin
          stateD = ST_IDLE;
        end else begin
          stateD       = ST_SETUP;
          ctl.incAddr  = 1'b1;
          ctl.loadData = isWriteQ && !isFillQ;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      isWriteQ <= 1'b0;
      isFillQ  <= 1'b0;
      lenLeftQ <= '0;
      cntQ     <= '0;
      done     <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= (accept && (len == '0)) || ((stateQ == ST_HOLD) && lastByte);
      if (accept) begin
        isWriteQ <= cmd[0];
        isFillQ  <= cmd[1] & cmd[0];
        lenLeftQ <= len;
      end else if ((stateQ == ST_HOLD) && !lastByte) begin
        lenLeftQ <= lenLeftQ - LEN_W'(1);
      end
      if ((stateQ == ST_STROBE) && !strobeEnd) cntQ <= cntQ + CNT_W'(1);
      else                                     cntQ <= '0;
    end
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/memSeqPath.sv
module memSeqPath
  import memSeqPkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtlS            ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] busIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busOut,
  output logic              dataOe,
  output logic              mreqN,
  output logic              rdN,
  output logic              wrN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (ctl.loadAddr)     addrQ <= startAddr;
      else if (ctl.incAddr) addrQ <= addrQ + ADDR_W'(1);
      if (ctl.loadData) dataQ <= wrData;
      if (ctl.capture)  rdData <= busIn;
      rdValid <= ctl.capture;
    end
  end

  assign busAddr = addrQ;
  assign busOut  = dataQ;
  assign dataOe  = ctl.drive;
  assign mreqN   = !ctl.mreqLow;
  assign rdN     = !ctl.rdLow;
  assign wrN     = !ctl.wrLow;

endmodule

// File: rtl/memCycleSeq.sv
module memCycleSeq
  import memSeqPkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter int WR_LOW = 2,
  parameter int RD_LOW = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [1:0]           cmd,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic [LEN_W-1:0]     len,
  input  logic [DATA_W-1:0]    wrData,
  output logic                 wrTake,
  output logic [7:0]           addrLo,
  output logic [7:0]           addrHi,
  output logic [ADDR_W-17:0]   addrBank,
  output logic [DATA_W-1:0]    busOut,
  output logic                 dataOe,
  input  logic [DATA_W-1:0]    busIn,
  output logic                 mreqN,
  output logic                 rdN,
  output logic                 wrN,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid,
  output logic                 busy,
  output logic                 done
);

  seqCtlS            ctl;
  logic [ADDR_W-1:0] busAddr;

  memSeqCtrl #(.LEN_W(LEN_W), .WR_LOW(WR_LOW), .RD_LOW(RD_LOW)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .len(len),
    .ctl(ctl), .busy(busy), .done(done)
  );

  memSeqPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .wrData(wrData), .busIn(busIn), .busAddr(busAddr), .busOut(busOut),
    .dataOe(dataOe), .mreqN(mreqN), .rdN(rdN), .wrN(wrN),
    .rdData(rdData), .rdValid(rdValid)
  );

  assign wrTake   = ctl.loadData;
  assign addrLo   = busAddr[7:0];
  assign addrHi   = busAddr[15:8];
  assign addrBank = busAddr[ADDR_W-1:16];

endmodule

// File: rtl/memCycleSeqChk.sv
module memCycleSeqChk (
  input logic clk,
  input logic rstN,
  input logic mreqN,
  input logic rdN,
  input logic wrN,
  input logic dataOe,
  input logic rdValid,
  input logic busy,
  input logic done
);

  // R11
  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R5
  a_r5_strobe_in_req: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> !mreqN);

  // R3
  a_r3_data_before_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |-> $past(dataOe));

  // R3
  a_r3_data_after_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrN) |-> dataOe);

  // R4
  a_r4_bus_released: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !dataOe);

  // R4
  a_r4_valid_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $rose(rdN));

  // R8
  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (mreqN && !busy));

  // R8
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind memCycleSeq memCycleSeqChk uChk (
  .clk(clk), .rstN(rstN), .mreqN(mreqN), .rdN(rdN), .wrN(wrN),
  .dataOe(dataOe), .rdValid(rdValid), .busy(busy), .done(done)
);

// File: tb/sim_memCycleSeq.sv
`timescale 1ns/1ps
module sim_memCycleSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic [18:0] startAddr = '0;
  logic [7:0]  len = '0;
  logic [7:0]  wrData = '0;
  logic        wrTake;
  logic [7:0]  addrLo, addrHi;
  logic [2:0]  addrBank;
  logic [7:0]  busOut;
  logic        dataOe;
  logic [7:0]  busIn;
  logic        mreqN, rdN, wrN;
  logic [7:0]  rdData;
  logic        rdValid, busy, done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  memCycleSeq u0 (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .startAddr(startAddr),
    .len(len), .wrData(wrData), .wrTake(wrTake), .addrLo(addrLo),
    .addrHi(addrHi), .addrBank(addrBank), .busOut(busOut), .dataOe(dataOe),
    .busIn(busIn), .mreqN(mreqN), .rdN(rdN), .wrN(wrN), .rdData(rdData),
    .rdValid(rdValid), .busy(busy), .done(done)
  );

  function automatic logic [7:0] memVal(input logic [18:0] a);
    return a[7:0] ^ {a[15:8]} ^ {a[18:16], 5'b10101};
  endfunction

  function automatic logic [7:0] pat(input int tag, input int k);
    return 8'(tag * 37 + k * 11 + 3);
  endfunction

  logic [18:0] curAddr;
  assign curAddr = {addrBank, addrHi, addrLo};
  assign busIn   = (!rdN) ? memVal(curAddr) : 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // transaction context
  int     txTag = 0, txLen = 0;
  logic [18:0] txBase = '0;
  bit     txWrite = 0, txFill = 0;
  int     wrFalls, rdFalls, mreqFalls, rdValids, takeCnt;
  int     wrRun, rdRun;
  bit     prevWrN = 1, prevRdN = 1, prevOe = 0, prevMreqN = 1, takePend = 0;

  // write data stream driver
  always @(negedge clk) takePend = wrTake;
  always @(posedge clk) begin
    #1;
    if (takePend) begin
      takeCnt++;
      wrData = pat(txTag, takeCnt);
    end
  end

  // bus monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (!rdN && !wrN) check(0, "R11", 0, 1);
      if (prevMreqN && !mreqN) mreqFalls++;
      if (!prevMreqN && mreqN)
        check(wrFalls + rdFalls == txLen, "R5", wrFalls + rdFalls, txLen);
      if (prevWrN && !wrN) begin
        check(prevOe == 1'b1, "R3", prevOe, 1);
        check(curAddr == 19'(txBase + 19'(wrFalls)), "R2", curAddr, txBase + 19'(wrFalls));
        if (txFill) check(busOut == pat(txTag, 0), "R6", busOut, pat(txTag, 0));
        else        check(busOut == pat(txTag, wrFalls), "R7", busOut, pat(txTag, wrFalls));
        wrFalls++;
        wrRun = 0;
      end
      if (!wrN) wrRun++;
      if (!prevWrN && wrN) begin
        check(wrRun == 2, "R3", wrRun, 2);
        check(dataOe == 1'b1, "R3", dataOe, 1);
      end
      if (prevRdN && !rdN) begin
        check(curAddr == 19'(txBase + 19'(rdFalls)), "R2", curAddr, txBase + 19'(rdFalls));
        rdFalls++;
        rdRun = 0;
      end
      if (!rdN) begin
        rdRun++;
        if (dataOe) check(0, "R4", dataOe, 0);
      end
      if (!prevRdN && rdN) check(rdRun == 3, "R4", rdRun, 3);
      if (rdValid) begin
        check(rdData == memVal(19'(txBase + 19'(rdValids))), "R4", rdData,
              memVal(19'(txBase + 19'(rdValids))));
        rdValids++;
      end
    end
    prevWrN = wrN; prevRdN = rdN; prevOe = dataOe; prevMreqN = mreqN;
  end

  task automatic runTx(input logic [1:0] c, input logic [18:0] a, input int n, input bit glitch);
    int per, expCyc, got;
    txTag++;
    txBase = a; txLen = n; txWrite = c[0]; txFill = (c == 2'b11);
    wrFalls = 0; rdFalls = 0; mreqFalls = 0; rdValids = 0; takeCnt = 0;
    wrData = pat(txTag, 0);
    @(posedge clk); #1;
    cmd = c; startAddr = a; len = 8'(n); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    per = txWrite ? 4 : 5;
    expCyc = n * per + 1;
    got = -1;
    for (int i = 1; i <= expCyc + 8 && got < 0; i++) begin
      @(negedge clk);
      if (done) got = i;
      if (glitch && i == 2) begin start = 1'b1; cmd = ~c; startAddr = a + 19'd77; len = 8'd9; end
      if (glitch && i == 3) start = 1'b0;
    end
    if (n == 0) check(got == expCyc, "R9", got, expCyc);
    else        check(got == expCyc, "R8", got, expCyc);
    @(negedge clk);
    check(!done, "R8", done, 0);
    check(mreqN && !busy, "R5", {mreqN, busy}, 2);
    check(mreqFalls == (n > 0 ? 1 : 0), n > 0 ? "R5" : "R9", mreqFalls, n > 0);
    check(wrFalls == (txWrite ? n : 0), glitch ? "R10" : "R7", wrFalls, txWrite ? n : 0);
    check(rdFalls == (txWrite ? 0 : n), glitch ? "R10" : "R4", rdFalls, txWrite ? 0 : n);
    check(rdValids == (txWrite ? 0 : n), "R4", rdValids, txWrite ? 0 : n);
    if (txFill) check(takeCnt == (n > 0 ? 1 : 0), "R6", takeCnt, n > 0);
    else if (txWrite) check(takeCnt == n, "R7", takeCnt, n);
    else check(takeCnt == 0, "R7", takeCnt, 0);
  endtask

  bit finished = 0;

  initial begin
    #(200000 * 20);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0]  cmds  [4] = '{2'b00, 2'b01, 2'b11, 2'b10};
    logic [18:0] addrs [4] = '{19'h00000, 19'h000FE, 19'h0FFFE, 19'h7FFFE};
    int          lens  [5] = '{0, 1, 2, 3, 5};
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(mreqN && rdN && wrN, "R1", {mreqN, rdN, wrN}, 7);
    check(!dataOe && !busy && !done && !rdValid, "R1",
          {dataOe, busy, done, rdValid}, 0);
    foreach (cmds[ci])
      foreach (addrs[ai])
        foreach (lens[li])
          runTx(cmds[ci], addrs[ai], lens[li], 1'b0);
    // R10: start pulsed while busy
    runTx(2'b01, 19'h12345, 4, 1'b1);
    runTx(2'b00, 19'h54321, 3, 1'b1);
    runTx(2'b11, 19'h3FFFF, 4, 1'b1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule